// File: doc/BRIEF.md
# Lockable Board Control Register Bank

This block is the control and identification register file of a processor core module. A host reaches it over a simple request/response bus. Each request carries a byte address in a 512-byte window, a write flag and a write word. Exactly one cycle later the block returns a response with read data and an error flag. The bank reports a fixed identity and a fixed status word. It holds two oscillator settings that software may change only after loading a 16-bit unlock key. It also holds a memory-configuration word and a memory-init word, plus two flag words. Each flag word has one address that ORs bits in and another that clears them.

A read-only window reports memory presence-detect bytes, one byte per word. The byte describing total memory size is set at elaboration from the `MEM_SIZE_MB` parameter, which also fixes the size code in the memory-configuration reset value. A small interrupt group holds a single software-driven raw source bit and two independent enable masks, one for the normal interrupt and one for the fast interrupt. Each mask has set and clear addresses and a masked-status view. A control word drives three registered outputs: the low-memory select (boot flash or RAM), an LED, and a one-cycle board reset request.

Top module: `board_ctrl_regs`

## Requirements
- R1: Word 0 (byte 0x000) reads 0x411A3001, word 4 (0x010) reads 0x00100000, and word 1 (0x004) reads 0. Words 32 to 35 (0x080 to 0x08C) read 0 and accept writes with no effect and no error.
- R2: A write to the key word (0x014) keeps only data bits 15:0. A read returns the kept value, with bit 16 set when the kept value equals 0xA05F.
- R3: Writes to the main oscillator word (0x008) and the auxiliary oscillator word (0x01C) update them only while the key word holds 0xA05F. Otherwise the write is dropped without error.
- R4: The flag word reads at 0x030. A write there ORs the data in, and a write to 0x034 clears the bits set in the data. The persistent flag word uses 0x038 (read and OR) and 0x03C (clear) in the same way.
- R5: Byte addresses 0x100 to 0x17F return, in bits 7:0, presence-detect byte number (address − 0x100)/4, with the upper bits zero. Byte 0 is 0x80, byte 9 is 0xA0, and byte 31 is 64/32/16/4/2 for at least 256/128/64/32 MB or smaller. Addresses 0x180 to 0x1FF read 0.
- R6: After reset, and after any later reset, the following values hold. Main oscillator is 0x01000048, auxiliary oscillator 0x0007FEFF, init word 0x00000112, and memory configuration 0x00011122 ORed with a size code. The size code is 0x10, 0x0C, 0x08 or 0x04 for at least 256, 128, 64 or 32 MB, and 0 below that; the default of 128 MB gives 0x0001112E. The key, control, flag and interrupt words are 0, and all outputs are low.
- R7: A write to the control word (0x00C) with data bit 3 set raises `reset_req` for exactly the one cycle after the write edge. Bit 3 is never stored and reads back 0.
- R8: Control bit 2 drives `low_ram_sel` and control bit 0 drives `led_on`, both updated at the write edge. The control word reads back its stored bits.
- R9: The software source is raw bit 0. A write to 0x050 with data bit 0 set raises it, and a write to 0x054 with data bit 0 set lowers it; other data bits have no effect. Raw reads at 0x044 and 0x050. The normal mask is set at 0x048 (also its read) and cleared at 0x04C, and 0x040 reads raw AND mask. The fast-interrupt copy uses 0x060 (masked), 0x064 (raw), 0x068 (mask set and read) and 0x06C (mask clear).
- R10: A read of an address not listed above, or a write to any address not listed as writable, returns zero data with `rsp_err` high in the response cycle and changes no state. Writable addresses: 0x008 to 0x01C except 0x010 and 0x018, 0x020, 0x024, 0x030 to 0x03C, 0x048, 0x04C, 0x050, 0x054, 0x068, 0x06C and 0x080 to 0x08C.
- R11: Every request gets `rsp_valid` exactly one cycle later. A request on the very next cycle already sees the effect of a write.
- R12: The memory configuration word (0x020) and init word (0x024) take every written bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Previous request hit an unimplemented address |
| low_ram_sel | output | 1 | 1 = RAM at low memory, 0 = boot flash |
| led_on | output | 1 | LED drive |
| reset_req | output | 1 | One-cycle board reset request |

## Verification
All results are due one clock edge after the request is sampled. Response data, the error flag and every register update land on that edge. `low_ram_sel` and `led_on` change on that edge, and `reset_req` is high only in the cycle that follows it. The bench drives each request on a falling edge and samples the response on the next falling edge. A reset pulse is checked as high at that point and low one cycle later. Requests are issued back to back, so read-after-write in the following cycle is exercised throughout the vector walk.

// File: rtl/bcr_pkg.sv
`timescale 1ns/1ps
package bcr_pkg;

  typedef logic [6:0] widx_t;

  // word indices of the map
  localparam widx_t W_ID       = 7'd0;
  localparam widx_t W_PROC     = 7'd1;
  localparam widx_t W_OSC      = 7'd2;
  localparam widx_t W_CTRL     = 7'd3;
  localparam widx_t W_STAT     = 7'd4;
  localparam widx_t W_KEY      = 7'd5;
  localparam widx_t W_AUX      = 7'd7;
  localparam widx_t W_MEMCFG   = 7'd8;
  localparam widx_t W_INIT     = 7'd9;
  localparam widx_t W_FLAG     = 7'd12;
  localparam widx_t W_FLAG_CLR = 7'd13;
  localparam widx_t W_NVF      = 7'd14;
  localparam widx_t W_NVF_CLR  = 7'd15;
  localparam widx_t W_IRQ_MSK  = 7'd16;
  localparam widx_t W_IRQ_RAW  = 7'd17;
  localparam widx_t W_IRQ_ENS  = 7'd18;
  localparam widx_t W_IRQ_ENC  = 7'd19;
  localparam widx_t W_SW_SET   = 7'd20;
  localparam widx_t W_SW_CLR   = 7'd21;
  localparam widx_t W_FIQ_MSK  = 7'd24;
  localparam widx_t W_FIQ_RAW  = 7'd25;
  localparam widx_t W_FIQ_ENS  = 7'd26;
  localparam widx_t W_FIQ_ENC  = 7'd27;
  localparam widx_t W_VOLT_LO  = 7'd32;
  localparam widx_t W_VOLT_HI  = 7'd35;

  localparam logic [31:0] ID_WORD     = 32'h411A3001;
  localparam logic [31:0] STAT_WORD   = 32'h00100000;
  localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;
  localparam logic [31:0] OSC_RST     = 32'h01000048;
  localparam logic [31:0] AUX_RST     = 32'h0007FEFF;
  localparam logic [31:0] INIT_RST    = 32'h00000112;
  localparam logic [31:0] MEMCFG_BASE = 32'h00011122;
  localparam int unsigned CTRL_RESET_BIT = 3;

  function automatic logic [7:0] size_code(input int unsigned mb);
    if (mb >= 256)     return 8'h10;
    else if (mb >= 128) return 8'h0C;
    else if (mb >= 64)  return 8'h08;
    else if (mb >= 32)  return 8'h04;
    else                return 8'h00;
  endfunction

  function automatic logic [7:0] size_byte(input int unsigned mb);
    if (mb >= 256)     return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  // presence-detect ROM; the final byte depends on memory size
  function automatic logic [7:0] pd_byte(input logic [4:0] i, input logic [7:0] last);
    case (i)
      5'd0:  return 8'h80;
      5'd1:  return 8'h08;
      5'd2:  return 8'h04;
      5'd3:  return 8'h0B;
      5'd4:  return 8'h09;
      5'd5:  return 8'h01;
      5'd6:  return 8'h40;
      5'd8:  return 8'h02;
      5'd9:  return 8'hA0;
      5'd10: return 8'hA0;
      5'd13: return 8'h08;
      5'd15: return 8'h01;
      5'd16: return 8'h0E;
      5'd17: return 8'h04;
      5'd18: return 8'h1C;
      5'd19: return 8'h01;
      5'd20: return 8'h02;
      5'd21: return 8'h20;
      5'd22: return 8'hC0;
      5'd27: return 8'h30;
      5'd28: return 8'h28;
      5'd29: return 8'h30;
      5'd30: return 8'h28;
      5'd31: return last;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/bcr_decode.sv
`timescale 1ns/1ps
module bcr_decode
  import bcr_pkg::*;
(
  input  widx_t      word,
  output logic       rd_ok,
  output logic       wr_ok,
  output logic       pd_hit,
  output logic [4:0] pd_idx
);

  logic volt;
  assign volt   = (word >= W_VOLT_LO) && (word <= W_VOLT_HI);
  assign pd_hit = (word[6:5] == 2'b10);
  assign pd_idx = word[4:0];

  always_comb begin
    rd_ok = word[6] || volt ||
            (word inside {W_ID, W_PROC, W_OSC, W_CTRL, W_STAT, W_KEY, W_AUX,
                          W_MEMCFG, W_INIT, W_FLAG, W_NVF, W_IRQ_MSK,
                          W_IRQ_RAW, W_IRQ_ENS, W_SW_SET, W_FIQ_MSK,
                          W_FIQ_RAW, W_FIQ_ENS});
    wr_ok = volt ||
            (word inside {W_OSC, W_CTRL, W_KEY, W_AUX, W_MEMCFG, W_INIT,
                          W_FLAG, W_FLAG_CLR, W_NVF, W_NVF_CLR, W_IRQ_ENS,
                          W_IRQ_ENC, W_SW_SET, W_SW_CLR, W_FIQ_ENS, W_FIQ_ENC});
  end

endmodule

// File: rtl/bcr_setclr.sv
`timescale 1ns/1ps
module bcr_setclr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);

  logic [W-1:0] set_bits, clr_bits;
  assign set_bits = set_en ? data : '0;
  assign clr_bits = clr_en ? data : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= (q | set_bits) & ~clr_bits;
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((q & $past(data)) == '0)) else $error("clear left bits set"); // R4

endmodule

// File: rtl/bcr_mask_bank.sv
`timescale 1ns/1ps
module bcr_mask_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  input  logic [W-1:0] raw,
  output logic [W-1:0] en_q,
  output logic [W-1:0] masked
);

  bcr_setclr #(.W(W), .RST_VAL('0)) u_en (
    .clk(clk), .rst(rst), .set_en(set_en), .clr_en(clr_en),
    .data(data), .q(en_q)
  );

  assign masked = raw & en_q;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    set_en && !clr_en |=> ((en_q & $past(data)) == $past(data))) else $error("mask set lost"); // R9

endmodule

// File: rtl/board_ctrl_regs.sv
`timescale 1ns/1ps
module board_ctrl_regs
  import bcr_pkg::*;
#(
  parameter int unsigned MEM_SIZE_MB = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [8:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        low_ram_sel,
  output logic        led_on,
  output logic        reset_req
);

  localparam logic [7:0]  SZ_CODE    = size_code(MEM_SIZE_MB);
  localparam logic [7:0]  PD_LAST    = size_byte(MEM_SIZE_MB);
  localparam logic [31:0] MEMCFG_RST = MEMCFG_BASE | {24'h0, SZ_CODE};
  localparam logic [31:0] CTRL_KEEP  = ~(32'h1 << CTRL_RESET_BIT);
  localparam int unsigned NCH = 2;  // 0: normal, 1: fast

  widx_t word;
  logic  unused_lo;
  assign word      = req_addr[8:2];
  assign unused_lo = ^req_addr[1:0];

  logic       rd_ok, wr_ok, pd_hit;
  logic [4:0] pd_idx;

  bcr_decode u_dec (
    .word(word), .rd_ok(rd_ok), .wr_ok(wr_ok), .pd_hit(pd_hit), .pd_idx(pd_idx)
  );

  logic wr_fire, rd_fire;
  assign wr_fire = req_valid && req_write && wr_ok;
  assign rd_fire = req_valid && !req_write && rd_ok;

  logic [31:0] osc_q, aux_q, ctrl_q, memcfg_q, init_q;
  logic [15:0] key_q;
  logic        soft_q;
  logic        unlocked;
  assign unlocked = (key_q == UNLOCK_KEY);

  logic osc_we, aux_we, ctrl_we, key_we, memcfg_we, init_we, sw_set, sw_clr;
  assign osc_we    = wr_fire && (word == W_OSC);
  assign aux_we    = wr_fire && (word == W_AUX);
  assign ctrl_we   = wr_fire && (word == W_CTRL);
  assign key_we    = wr_fire && (word == W_KEY);
  assign memcfg_we = wr_fire && (word == W_MEMCFG);
  assign init_we   = wr_fire && (word == W_INIT);
  assign sw_set    = wr_fire && (word == W_SW_SET) && req_wdata[0];
  assign sw_clr    = wr_fire && (word == W_SW_CLR) && req_wdata[0];

  // flag words: index 0 volatile, index 1 persistent
  logic [1:0]        fl_set, fl_clr;
  logic [1:0][31:0]  fl_q;
  assign fl_set[0] = wr_fire && (word == W_FLAG);
  assign fl_clr[0] = wr_fire && (word == W_FLAG_CLR);
  assign fl_set[1] = wr_fire && (word == W_NVF);
  assign fl_clr[1] = wr_fire && (word == W_NVF_CLR);

  for (genvar g = 0; g < 2; g++) begin : g_flags
    bcr_setclr #(.W(32), .RST_VAL('0)) u_fl (
      .clk(clk), .rst(rst), .set_en(fl_set[g]), .clr_en(fl_clr[g]),
      .data(req_wdata), .q(fl_q[g])
    );
  end

  // interrupt masks, one bank per channel
  logic [31:0]          raw;
  logic [NCH-1:0]       mk_set, mk_clr;
  logic [NCH-1:0][31:0] en_q, masked;
  assign raw       = {31'h0, soft_q};
  assign mk_set[0] = wr_fire && (word == W_IRQ_ENS);
  assign mk_clr[0] = wr_fire && (word == W_IRQ_ENC);
  assign mk_set[1] = wr_fire && (word == W_FIQ_ENS);
  assign mk_clr[1] = wr_fire && (word == W_FIQ_ENC);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    bcr_mask_bank #(.W(32)) u_mask (
      .clk(clk), .rst(rst), .set_en(mk_set[c]), .clr_en(mk_clr[c]),
      .data(req_wdata), .raw(raw), .en_q(en_q[c]), .masked(masked[c])
    );
  end

  // state registers
  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q     <= OSC_RST;
      aux_q     <= AUX_RST;
      key_q     <= '0;
      ctrl_q    <= '0;
      memcfg_q  <= MEMCFG_RST;
      init_q    <= INIT_RST;
      soft_q    <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (osc_we && unlocked) osc_q <= req_wdata;
      if (aux_we && unlocked) aux_q <= req_wdata;
      if (key_we)    key_q    <= req_wdata[15:0];
      if (ctrl_we)   ctrl_q   <= req_wdata & CTRL_KEEP;
      if (memcfg_we) memcfg_q <= req_wdata;
      if (init_we)   init_q   <= req_wdata;
      if (sw_set)      soft_q <= 1'b1;
      else if (sw_clr) soft_q <= 1'b0;
      reset_req <= ctrl_we && req_wdata[CTRL_RESET_BIT];
    end
  end

  assign low_ram_sel = ctrl_q[2];
  assign led_on      = ctrl_q[0];

  // read multiplexer
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (pd_hit) begin
      rd_mux = {24'h0, pd_byte(pd_idx, PD_LAST)};
    end else begin
      case (word)
        W_ID:      rd_mux = ID_WORD;
        W_STAT:    rd_mux = STAT_WORD;
        W_OSC:     rd_mux = osc_q;
        W_CTRL:    rd_mux = ctrl_q;
        W_KEY:     rd_mux = {15'h0, unlocked, key_q};
        W_AUX:     rd_mux = aux_q;
        W_MEMCFG:  rd_mux = memcfg_q;
        W_INIT:    rd_mux = init_q;
        W_FLAG:    rd_mux = fl_q[0];
        W_NVF:     rd_mux = fl_q[1];
        W_IRQ_MSK: rd_mux = masked[0];
        W_IRQ_RAW: rd_mux = raw;
        W_IRQ_ENS: rd_mux = en_q[0];
        W_SW_SET:  rd_mux = raw;
        W_FIQ_MSK: rd_mux = masked[1];
        W_FIQ_RAW: rd_mux = raw;
        W_FIQ_ENS: rd_mux = en_q[1];
        default:   rd_mux = '0;
      endcase
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_fire ? rd_mux : '0;
      rsp_err   <= req_valid && (req_write ? !wr_ok : !rd_ok);
    end
  end

  AST_OSC_GUARD: assert property (@(posedge clk) disable iff (rst)
    !$stable(osc_q) |-> $past(osc_we && unlocked)) else $error("oscillator changed while locked"); // R3
  AST_RESET_WITH_CTRL: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (low_ram_sel == $past(req_wdata[2]))) else $error("reset pulse without control update"); // R7
  AST_LED_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(led_on) |-> $past(req_valid && req_write)) else $error("led moved without write"); // R8
  AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid) else $error("error outside response"); // R10
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid) else $error("response missing"); // R11

endmodule

// File: tb/board_ctrl_regs_test.sv
`timescale 1ns/1ps
module board_ctrl_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, low_ram_sel, led_on, reset_req;
  logic [31:0] rsp_rdata;

  always #2.5 clk = ~clk;

  board_ctrl_regs #(.MEM_SIZE_MB(128)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .low_ram_sel(low_ram_sel),
    .led_on(led_on), .reset_req(reset_req)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge with the response visible
  task automatic xact(input logic wr, input logic [8:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [8:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic        err;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 9'h000, 32'h0,        32'h411A3001, 1'b0, 4'd1},  // R1
    '{1'b0, 9'h004, 32'h0,        32'h00000000, 1'b0, 4'd1},  // R1
    '{1'b0, 9'h010, 32'h0,        32'h00100000, 1'b0, 4'd1},  // R1
    '{1'b0, 9'h080, 32'h0,        32'h00000000, 1'b0, 4'd1},  // R1
    '{1'b1, 9'h084, 32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd1},  // R1
    '{1'b0, 9'h08C, 32'h0,        32'h00000000, 1'b0, 4'd1},  // R1
    '{1'b0, 9'h008, 32'h0,        32'h01000048, 1'b0, 4'd6},  // R6
    '{1'b0, 9'h01C, 32'h0,        32'h0007FEFF, 1'b0, 4'd6},  // R6
    '{1'b0, 9'h024, 32'h0,        32'h00000112, 1'b0, 4'd6},  // R6
    '{1'b0, 9'h020, 32'h0,        32'h0001112E, 1'b0, 4'd6},  // R6
    '{1'b0, 9'h014, 32'h0,        32'h00000000, 1'b0, 4'd6},  // R6
    '{1'b1, 9'h008, 32'h12345678, 32'h00000000, 1'b0, 4'd3},  // R3 locked
    '{1'b0, 9'h008, 32'h0,        32'h01000048, 1'b0, 4'd3},  // R3
    '{1'b1, 9'h014, 32'hFFFFA05F, 32'h00000000, 1'b0, 4'd2},  // R2
    '{1'b0, 9'h014, 32'h0,        32'h0001A05F, 1'b0, 4'd2},  // R2
    '{1'b1, 9'h008, 32'h12345678, 32'h00000000, 1'b0, 4'd3},  // R3 unlocked
    '{1'b0, 9'h008, 32'h0,        32'h12345678, 1'b0, 4'd3},  // R3
    '{1'b1, 9'h01C, 32'h0000ABCD, 32'h00000000, 1'b0, 4'd3},  // R3
    '{1'b0, 9'h01C, 32'h0,        32'h0000ABCD, 1'b0, 4'd3},  // R3
    '{1'b1, 9'h014, 32'h00001234, 32'h00000000, 1'b0, 4'd2},  // R2
    '{1'b0, 9'h014, 32'h0,        32'h00001234, 1'b0, 4'd2},  // R2
    '{1'b1, 9'h01C, 32'h11111111, 32'h00000000, 1'b0, 4'd3},  // R3 locked again
    '{1'b0, 9'h01C, 32'h0,        32'h0000ABCD, 1'b0, 4'd3},  // R3
    '{1'b1, 9'h020, 32'hDEADBEEF, 32'h00000000, 1'b0, 4'd12}, // R12
    '{1'b0, 9'h020, 32'h0,        32'hDEADBEEF, 1'b0, 4'd12}, // R12
    '{1'b1, 9'h024, 32'h00000000, 32'h00000000, 1'b0, 4'd12}, // R12
    '{1'b0, 9'h024, 32'h0,        32'h00000000, 1'b0, 4'd12}, // R12
    '{1'b1, 9'h030, 32'hF0F0000F, 32'h00000000, 1'b0, 4'd4},  // R4
    '{1'b1, 9'h030, 32'h00000F00, 32'h00000000, 1'b0, 4'd4},  // R4
    '{1'b0, 9'h030, 32'h0,        32'hF0F00F0F, 1'b0, 4'd4},  // R4
    '{1'b1, 9'h034, 32'hF000000F, 32'h00000000, 1'b0, 4'd4},  // R4
    '{1'b0, 9'h030, 32'h0,        32'h00F00F00, 1'b0, 4'd4},  // R4
    '{1'b1, 9'h038, 32'h0000FFFF, 32'h00000000, 1'b0, 4'd4},  // R4
    '{1'b1, 9'h03C, 32'h000000FF, 32'h00000000, 1'b0, 4'd4},  // R4
    '{1'b0, 9'h038, 32'h0,        32'h0000FF00, 1'b0, 4'd4},  // R4
    '{1'b0, 9'h034, 32'h0,        32'h00000000, 1'b1, 4'd10}, // R10
    '{1'b0, 9'h018, 32'h0,        32'h00000000, 1'b1, 4'd10}, // R10
    '{1'b1, 9'h000, 32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd10}, // R10
    '{1'b0, 9'h02C, 32'h0,        32'h00000000, 1'b1, 4'd10}, // R10
    '{1'b1, 9'h040, 32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd10}, // R10
    '{1'b1, 9'h048, 32'h00000003, 32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h048, 32'h0,        32'h00000003, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h044, 32'h0,        32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b1, 9'h050, 32'hFFFFFFFE, 32'h00000000, 1'b0, 4'd9},  // R9 bit0 clear: no effect
    '{1'b0, 9'h050, 32'h0,        32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b1, 9'h050, 32'h00000001, 32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h044, 32'h0,        32'h00000001, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h040, 32'h0,        32'h00000001, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h060, 32'h0,        32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b1, 9'h068, 32'h00000001, 32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h060, 32'h0,        32'h00000001, 1'b0, 4'd9},  // R9
    '{1'b1, 9'h04C, 32'h00000001, 32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h040, 32'h0,        32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h048, 32'h0,        32'h00000002, 1'b0, 4'd9},  // R9
    '{1'b1, 9'h054, 32'h00000001, 32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h064, 32'h0,        32'h00000000, 1'b0, 4'd9},  // R9
    '{1'b0, 9'h100, 32'h0,        32'h00000080, 1'b0, 4'd5},  // R5
    '{1'b0, 9'h124, 32'h0,        32'h000000A0, 1'b0, 4'd5},  // R5
    '{1'b0, 9'h17C, 32'h0,        32'h00000020, 1'b0, 4'd5},  // R5
    '{1'b0, 9'h180, 32'h0,        32'h00000000, 1'b0, 4'd5},  // R5
    '{1'b0, 9'h1FC, 32'h0,        32'h00000000, 1'b0, 4'd5},  // R5
    '{1'b1, 9'h100, 32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd10}, // R10
    '{1'b1, 9'h00C, 32'h00000005, 32'h00000000, 1'b0, 4'd8},  // R8
    '{1'b0, 9'h00C, 32'h0,        32'h00000005, 1'b0, 4'd8}   // R8
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 outputs after reset
    check("R6 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R6 rsp_err", {31'h0, rsp_err}, 32'h0);
    check("R6 led_on", {31'h0, led_on}, 32'h0);
    check("R6 low_ram_sel", {31'h0, low_ram_sel}, 32'h0);
    check("R6 reset_req", {31'h0, reset_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i].wr, VEC[i].a, VEC[i].d);
      check($sformatf("R%0d vec%0d valid", VEC[i].tag, i), {31'h0, rsp_valid}, 32'h1);
      check($sformatf("R%0d vec%0d data", VEC[i].tag, i), rsp_rdata, VEC[i].e);
      check($sformatf("R%0d vec%0d err", VEC[i].tag, i), {31'h0, rsp_err}, {31'h0, VEC[i].err});
    end

    // R8 outputs follow control bits 2 and 0
    check("R8 led_on after ctrl=5", {31'h0, led_on}, 32'h1);
    check("R8 low_ram_sel after ctrl=5", {31'h0, low_ram_sel}, 32'h1);

    // R7 reset request pulse
    check("R7 idle reset_req", {31'h0, reset_req}, 32'h0);
    xact(1'b1, 9'h00C, 32'h0000000C);
    check("R7 pulse high", {31'h0, reset_req}, 32'h1);
    check("R8 led_on off", {31'h0, led_on}, 32'h0);
    check("R8 low_ram_sel kept", {31'h0, low_ram_sel}, 32'h1);
    xact(1'b0, 9'h00C, 32'h0);
    check("R7 pulse one cycle", {31'h0, reset_req}, 32'h0);
    check("R7 bit3 not stored", rsp_rdata, 32'h00000004);
    xact(1'b1, 9'h00C, 32'h00000000);
    check("R8 low_ram_sel boot", {31'h0, low_ram_sel}, 32'h0);
    check("R7 no pulse without bit3", {31'h0, reset_req}, 32'h0);

    // R11 back-to-back read after write, then idle
    xact(1'b1, 9'h020, 32'h0000CAFE);
    check("R11 write valid", {31'h0, rsp_valid}, 32'h1);
    xact(1'b0, 9'h020, 32'h0);
    check("R11 read after write", rsp_rdata, 32'h0000CAFE);
    @(negedge clk);
    check("R11 idle no response", {31'h0, rsp_valid}, 32'h0);

    // R6 reset in the middle of operation
    xact(1'b1, 9'h00C, 32'h00000005);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R6 led_on cleared", {31'h0, led_on}, 32'h0);
    check("R6 low_ram_sel cleared", {31'h0, low_ram_sel}, 32'h0);
    xact(1'b0, 9'h020, 32'h0);
    check("R6 memcfg re-reset", rsp_rdata, 32'h0001112E);
    xact(1'b0, 9'h030, 32'h0);
    check("R6 flags re-reset", rsp_rdata, 32'h00000000);
    xact(1'b0, 9'h008, 32'h0);
    check("R6 osc re-reset", rsp_rdata, 32'h01000048);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule